// File: doc/BRIEF.md
# TDM Serial Input Capture

This block turns a group of time-division-multiplexed serial input lines into 8-bit channel bytes. It keeps each byte in a capture memory indexed by stream and by channel. All lines share one bit strobe and one frame-alignment pulse. A bit counter and a channel counter, both cleared by the alignment pulse, tell where each incoming bit belongs. When the eighth bit of a channel arrives, the byte for that channel is written for every stream in the same clock cycle.

A mode input sets the bit order within a byte. In MSB-first order the first bit on the line becomes bit 7. In LSB-first order the first bit on the line becomes bit 0. A host reads the capture memory through a simple select/write-enable/address port. The port returns a 16-bit word whose upper byte is always zero. Host write strobes do not change the memory. The line rate is fixed at build time by the `RATE_MBPS` parameter: 8 gives 128 channels per frame, and 16 gives 256.

Top module: `tdm_capture`

## Requirements
- R1: The capture memory holds 2^(STREAM_W+CHAN_W) bytes (4096 at the defaults). The host address is {stream, channel}: the stream number sits in the upper STREAM_W bits (11:7 at the defaults) and the channel number in the lower CHAN_W bits (6:0).
- R2: With `lsb_first` = 0, the first bit received for a channel is stored in bit 7 and the eighth bit in bit 0.
- R3: With `lsb_first` = 1, the first bit received for a channel is stored in bit 0 and the eighth bit in bit 7.
- R4: A cycle with `frame_sync` high clears the bit and channel counters. The first `bit_tick` after it carries bit 0 of channel 0. The channel number then advances after every eighth tick.
- R5: A byte is written only in the cycle of the eighth tick of its channel. If a frame pulse cuts a channel short, that channel's memory entry keeps its previous value.
- R6: A host write strobe (`cpu_sel` = 1, `cpu_we` = 1) changes no memory location and leaves `cpu_rdata` unchanged.
- R7: A host read (`cpu_sel` = 1, `cpu_we` = 0) loads `cpu_rdata` at the next clock edge. Bits 7:0 hold the addressed byte and bits 15:8 are always zero.
- R8: After reset, every memory location reads 8'h00 and `cpu_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bit_tick | input | 1 | One-cycle strobe for each serial bit period |
| frame_sync | input | 1 | Frame alignment pulse; clears the bit and channel counters |
| lsb_first | input | 1 | Bit order: 0 = first bit to bit 7, 1 = first bit to bit 0 |
| ser_in | input | 2^STREAM_W (32) | One serial data line per stream, sampled on `bit_tick` |
| cpu_sel | input | 1 | Host access strobe |
| cpu_we | input | 1 | Host access is a write (ignored) |
| cpu_addr | input | STREAM_W+CHAN_W (12) | Host address {stream, channel} |
| cpu_rdata | output | 16 | Read word: {8'h00, channel byte} |

## Verification
A channel byte is committed at the clock edge that samples its eighth `bit_tick`. A host read returns it one edge after the read strobe. The bench therefore reads only after the last tick of a frame has been taken in. It drives every input on a falling edge and samples `cpu_rdata` on the falling edge that follows the read edge. For a write strobe, `cpu_rdata` is sampled on the next falling edge and then the same address is read back, so a register that changed at that edge would show up.

// File: rtl/tdm_capture_pkg.sv
package tdm_capture_pkg;

  typedef logic [7:0] chan_byte_t;

  // Insert one serial bit into a partly assembled channel byte.
  // MSB-first: earliest bit ends in bit 7; LSB-first: earliest bit ends in bit 0.
  function automatic chan_byte_t shift_in(input chan_byte_t cur, input logic din,
                                          input logic lsb_first);
    chan_byte_t nxt;
    if (lsb_first) nxt = {din, cur[7:1]};
    else           nxt = {cur[6:0], din};
    return nxt;
  endfunction

endpackage

// File: rtl/tdm_capture_timing.sv
module tdm_capture_timing #(
  parameter int CHAN_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              frame_sync,
  output logic [2:0]        bit_cnt,
  output logic [CHAN_W-1:0] chan_cnt,
  output logic              commit
);

  logic [2:0]        bit_nxt;
  logic [CHAN_W-1:0] chan_nxt;
  logic              cnt_en;

  always_comb begin
    bit_nxt  = bit_cnt;
    chan_nxt = chan_cnt;
    cnt_en   = frame_sync | bit_tick;
    if (frame_sync) begin
      bit_nxt  = '0;
      chan_nxt = '0;
    end else if (bit_tick) begin
      bit_nxt = bit_cnt + 3'd1;
      if (bit_cnt == 3'd7) chan_nxt = chan_cnt + 1'b1;
    end
  end

  assign commit = bit_tick & ~frame_sync & (bit_cnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      chan_cnt <= '0;
    end else if (cnt_en) begin
      bit_cnt  <= bit_nxt;
      chan_cnt <= chan_nxt;
    end
  end

endmodule

// File: rtl/tdm_capture_deser.sv
module tdm_capture_deser
  import tdm_capture_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       frame_sync,
  input  logic       lsb_first,
  input  logic       din,
  output chan_byte_t byte_nxt
);

  chan_byte_t shreg;
  logic       sh_en;

  always_comb begin
    sh_en    = frame_sync | bit_tick;
    byte_nxt = shreg;
    if (frame_sync)    byte_nxt = '0;
    else if (bit_tick) byte_nxt = shift_in(shreg, din, lsb_first);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shreg <= '0;
    else if (sh_en) shreg <= byte_nxt;
  end

endmodule

// File: rtl/tdm_capture_store.sv
module tdm_capture_store
  import tdm_capture_pkg::*;
#(
  parameter int STREAM_W = 5,
  parameter int CHAN_W   = 7,
  localparam int NSTREAM = 1 << STREAM_W,
  localparam int NCHAN   = 1 << CHAN_W,
  localparam int ADDR_W  = STREAM_W + CHAN_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [CHAN_W-1:0]                wr_chan,
  input  logic [NSTREAM-1:0][7:0]          wr_bytes,
  input  logic                             rd_en,
  input  logic [ADDR_W-1:0]                rd_addr,
  output chan_byte_t                       rd_byte
);

  chan_byte_t          mem [NSTREAM][NCHAN];
  logic [STREAM_W-1:0] rd_stream;
  logic [CHAN_W-1:0]   rd_chan;
  chan_byte_t          rd_nxt;

  assign rd_stream = rd_addr[ADDR_W-1:CHAN_W];
  assign rd_chan   = rd_addr[CHAN_W-1:0];
  assign rd_nxt    = mem[rd_stream][rd_chan];

  // One row per stream; all rows take the same channel column on a commit.
  for (genvar s = 0; s < NSTREAM; s++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int c = 0; c < NCHAN; c++) mem[s][c] <= '0;
      end else if (wr_en) begin
        mem[s][wr_chan] <= wr_bytes[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_byte <= '0;
    else if (rd_en) rd_byte <= rd_nxt;
  end

endmodule

// File: rtl/tdm_capture.sv
module tdm_capture
  import tdm_capture_pkg::*;
#(
  parameter int RATE_MBPS = 8,
  parameter int STREAM_W  = 5,
  localparam int CHAN_W   = (RATE_MBPS == 16) ? 8 : 7,
  localparam int NSTREAM  = 1 << STREAM_W,
  localparam int ADDR_W   = STREAM_W + CHAN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               frame_sync,
  input  logic               lsb_first,
  input  logic [NSTREAM-1:0] ser_in,
  input  logic               cpu_sel,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  output logic [15:0]        cpu_rdata
);

  logic [1:0]             rst_pipe;
  logic                   rst_q_n;
  logic [2:0]             bit_cnt;
  logic [CHAN_W-1:0]      chan_cnt;
  logic                   commit;
  logic [NSTREAM-1:0][7:0] lane_bytes;
  logic                   rd_en;
  chan_byte_t             rd_byte;

  // Asserted asynchronously, released on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  tdm_capture_timing #(.CHAN_W(CHAN_W)) u_timing (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .bit_tick   (bit_tick),
    .frame_sync (frame_sync),
    .bit_cnt    (bit_cnt),
    .chan_cnt   (chan_cnt),
    .commit     (commit)
  );

  for (genvar s = 0; s < NSTREAM; s++) begin : g_lane
    tdm_capture_deser u_deser (
      .clk        (clk),
      .rst_n      (rst_q_n),
      .bit_tick   (bit_tick),
      .frame_sync (frame_sync),
      .lsb_first  (lsb_first),
      .din        (ser_in[s]),
      .byte_nxt   (lane_bytes[s])
    );
  end

  assign rd_en = cpu_sel & ~cpu_we;

  tdm_capture_store #(.STREAM_W(STREAM_W), .CHAN_W(CHAN_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_en    (commit),
    .wr_chan  (chan_cnt),
    .wr_bytes (lane_bytes),
    .rd_en    (rd_en),
    .rd_addr  (cpu_addr),
    .rd_byte  (rd_byte)
  );

  assign cpu_rdata = {8'h00, rd_byte};

endmodule

// File: rtl/tdm_capture_chk.sv
module tdm_capture_chk (
  input logic        clk,
  input logic        rst_q_n,
  input logic        bit_tick,
  input logic        frame_sync,
  input logic [2:0]  bit_cnt,
  input logic        commit,
  input logic        cpu_sel,
  input logic        cpu_we,
  input logic [15:0] cpu_rdata
);

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    cpu_rdata[15:8] == 8'h00);

  // R4
  frame_align_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    frame_sync |=> bit_cnt == 3'd0);

  // R4
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bit_tick && !frame_sync) |=> bit_cnt == $past(bit_cnt) + 3'd1);

  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!bit_tick && !frame_sync) |=> $stable(bit_cnt));

  // R5
  full_byte_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    commit |-> (bit_tick && !frame_sync && bit_cnt == 3'd7));

  // R6
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cpu_sel && cpu_we) |=> $stable(cpu_rdata));

endmodule

bind tdm_capture tdm_capture_chk u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .bit_tick   (bit_tick),
  .frame_sync (frame_sync),
  .bit_cnt    (bit_cnt),
  .commit     (commit),
  .cpu_sel    (cpu_sel),
  .cpu_we     (cpu_we),
  .cpu_rdata  (cpu_rdata)
);

// File: tb/tdm_capture_tb.sv
module tdm_capture_tb;

  localparam int SW     = 5;
  localparam int CW     = 7;
  localparam int NS     = 1 << SW;
  localparam int NC     = 1 << CW;
  localparam int AW     = SW + CW;

  logic          clk;
  logic          rst_n;
  logic          bit_tick;
  logic          frame_sync;
  logic          lsb_first;
  logic [NS-1:0] ser_in;
  logic          cpu_sel;
  logic          cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [15:0]   cpu_rdata;

  int  n_total = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  tdm_capture #(.RATE_MBPS(8), .STREAM_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_sync(frame_sync),
    .lsb_first(lsb_first), .ser_in(ser_in), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input int s, input int c, input int pass);
    return 8'(((s * 29) + (c * 7) + (pass * 83)) ^ (c >> 1));
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7 - i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_sync = 1'b1;
    @(negedge clk); frame_sync = 1'b0;
  endtask

  // Line order: bit k of the serial sequence is pat[7-k].
  task automatic send_chan(input int c, input int pass, input int nbits);
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      for (int s = 0; s < NS; s++) ser_in[s] = pat(s, c, pass)[7 - k];
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  endtask

  task automatic rd(input int s, input int c, output logic [15:0] v);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = AW'((s << CW) | c);
    @(negedge clk);
    cpu_sel = 1'b0;
    v = cpu_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] held;
    rst_n = 1'b0; bit_tick = 1'b0; frame_sync = 1'b0; lsb_first = 1'b0;
    ser_in = '0; cpu_sel = 1'b0; cpu_we = 1'b0; cpu_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 reset state
    chk("R8 rdata after reset", cpu_rdata, 16'h0000);
    for (int s = 0; s < NS; s += 7)
      for (int c = 0; c < NC; c += 31) begin
        rd(s, c, v); chk("R8 location cleared", v, 16'h0000);
      end
    rd(NS - 1, NC - 1, v); chk("R8 last location cleared", v, 16'h0000);

    // R2 MSB-first full frame, R1 address split, R7 upper byte
    lsb_first = 1'b0;
    pulse_frame();
    for (int c = 0; c < NC; c++) send_chan(c, 0, 8);
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++) begin
        rd(s, c, v); chk("R2/R1/R7 msb-first byte", v, {8'h00, pat(s, c, 0)});
      end

    // R3 LSB-first full frame
    lsb_first = 1'b1;
    pulse_frame();
    for (int c = 0; c < NC; c++) send_chan(c, 1, 8);
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++) begin
        rd(s, c, v); chk("R3/R1 lsb-first byte", v, {8'h00, rev8(pat(s, c, 1))});
      end

    // R5 cut-short channel, R4 realignment after mid-channel pulse
    lsb_first = 1'b0;
    pulse_frame();
    send_chan(0, 2, 8);
    send_chan(1, 2, 5);
    pulse_frame();
    send_chan(0, 3, 8);
    for (int s = 0; s < NS; s++) begin
      rd(s, 0, v); chk("R4 realigned channel 0", v, {8'h00, pat(s, 0, 3)});
      rd(s, 1, v); chk("R5 cut channel kept", v, {8'h00, rev8(pat(s, 1, 1))});
      rd(s, 2, v); chk("R5 untouched channel kept", v, {8'h00, rev8(pat(s, 2, 1))});
    end

    // R6 host write strobes ignored
    for (int s = 0; s < NS; s += 5) begin
      rd(s, 9, held);
      @(negedge clk);
      cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = AW'((s << CW) | 9);
      @(negedge clk);
      cpu_sel = 1'b0; cpu_we = 1'b0;
      chk("R6 rdata held on write", cpu_rdata, held);
      rd(s, 9, v); chk("R6 memory unchanged by write", v, {8'h00, rev8(pat(s, 9, 1))});
    end

    done = 1;
    summary();
  end

endmodule